// File: doc/BRIEF.md
# Page Ring Packet Buffer Manager

This block owns an 8 KB packet store cut into 32 pages of 256 bytes. A run-time split value `n` (0 to 31) places the receive region on pages 0 to n-1 and the transmit region on pages n to 31. Each region is run as a circular ring of pages. An allocate request takes the page at the head. A release request gives back the page at the tail.

Two clients reach the store. A network engine moves whole 32-bit words, addressed by page and word index. A host moves single bytes, addressed by page and byte offset. Writing the split register re-seats both rings on the new boundary and empties the receive ring. It also raises a one-cycle pulse so that a neighbouring receive status queue can discard its entries.

Top module: `pbm_mgr`

## Requirements
- R1: After a synchronous active-low reset the split is 8. The receive head and tail are page 0, the transmit head and tail are page 8, both rings report empty, and the flush pulse is low.
- R2: An allocate request on a ring that is not full moves its head to the next page of that region, one clock later. A release request on a ring that is not empty moves its tail the same way. A request on a full ring (allocate) or on an empty ring (release) changes no pointer.
- R3: A head or tail that sits on its region's last page moves to the region's first page. The receive region runs from page 0 to page n-1 and the transmit region from page n to page 31.
- R4: A ring reports empty when its head equals its tail. It reports full when the page after the head is the tail, so a region of s pages holds at most s-1 allocated pages, and a one-page region is always full.
- R5: With a split of 0 the receive ring reports both full and empty, and it refuses every allocate request. The transmit ring then spans pages 0 to 31.
- R6: A write to the split register has three effects one clock later. The split output shows the new value, the receive head and tail are page 0, and the transmit head and tail are the new split value. Allocate and release requests in that same cycle are ignored. The flush pulse is high for exactly the cycle after the write.
- R7: An engine access uses word address page*64 + word index. Its write stores all 32 bits. Its read data appears one clock after the request.
- R8: A host access uses byte address page*256 + offset. The low two offset bits pick byte lane k, which is bits 8k+7 to 8k of the word. A host write changes only that byte. Host read data appears one clock after the request.
- R9: If the engine and the host write the same word in the same cycle, the engine's word is what the store keeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| split_we | input | 1 | Write strobe for the split register |
| split_val | input | 5 | New split value n |
| split_o | output | 5 | Current split value |
| rx_flush_o | output | 1 | One-cycle receive flush pulse after a split write |
| rx_alloc | input | 1 | Allocate a receive page |
| rx_release | input | 1 | Release a receive page |
| tx_alloc | input | 1 | Allocate a transmit page |
| tx_release | input | 1 | Release a transmit page |
| rx_head | output | 5 | Receive head page |
| rx_tail | output | 5 | Receive tail page |
| rx_full | output | 1 | Receive ring full |
| rx_empty | output | 1 | Receive ring empty |
| tx_head | output | 5 | Transmit head page |
| tx_tail | output | 5 | Transmit tail page |
| tx_full | output | 1 | Transmit ring full |
| tx_empty | output | 1 | Transmit ring empty |
| eng_en | input | 1 | Engine access enable |
| eng_we | input | 1 | Engine write enable |
| eng_page | input | 5 | Engine page number |
| eng_word | input | 6 | Engine word index within the page |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data |
| host_en | input | 1 | Host access enable |
| host_we | input | 1 | Host write enable |
| host_page | input | 5 | Host page number |
| host_off | input | 8 | Host byte offset within the page |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |

## Verification
Every result of this block is due exactly one clock after the request that causes it. This holds for pointer moves, full and empty flags, split updates and read data. The flush pulse is high only in the cycle after a split write, so it is checked both in that cycle and in the cycle that follows. Each bench request queues its expected values tagged with the cycle one edge after it is driven. A monitor compares them at the falling edge of that cycle, which keeps every check at the clock in which the result is due.

// File: rtl/pbm_pkg.sv
// pbm_pkg: shared defaults and the region selector for the page buffer manager.
// Assumes the page count, page size and word size are powers of two.
package pbm_pkg;
    localparam int PBM_PAGES      = 32;
    localparam int PBM_PAGE_BYTES = 256;
    localparam int PBM_WORD_BYTES = 4;
    localparam int PBM_RST_SPLIT  = 8;

    typedef enum int {
        REG_RX = 0,
        REG_TX = 1
    } region_e;
endpackage

// File: rtl/pbm_split.sv
// pbm_split: holds the partition value and produces the receive flush pulse.
// Assumes a write may occur in any cycle; each write, even of the same value,
// restarts both rings.
module pbm_split #(
    parameter int PG_W      = 5,
    parameter int RST_SPLIT = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [PG_W-1:0] wr_val,
    output logic [PG_W-1:0] split_q,
    output logic            flush_q
);
    // Capture the split value and flag a flush for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            split_q <= PG_W'(RST_SPLIT);
            flush_q <= 1'b0;
        end else begin
            flush_q <= wr_en;
            if (wr_en) split_q <= wr_val;
        end
    end
endmodule

// File: rtl/pbm_ring.sv
// pbm_ring: circular head/tail page pointers for one region [base, last].
// Assumes base <= last whenever no_room is low; keeps one page spare to tell
// a full ring from an empty one. A load re-seats both pointers and overrides
// any request in the same cycle.
module pbm_ring #(
    parameter int PG_W     = 5,
    parameter int RST_BASE = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PG_W-1:0] load_base,
    input  logic [PG_W-1:0] base,
    input  logic [PG_W-1:0] last,
    input  logic            no_room,
    input  logic            alloc,
    input  logic            release_pg,
    output logic [PG_W-1:0] head,
    output logic [PG_W-1:0] tail,
    output logic            full,
    output logic            empty
);
    logic [PG_W-1:0] head_nx;
    logic [PG_W-1:0] tail_nx;

    // Successor pages, wrapping from the region's last page to its first.
    always_comb begin
        head_nx = (head == last) ? base : head + PG_W'(1);
        tail_nx = (tail == last) ? base : tail + PG_W'(1);
    end

    // Ring state flags.
    assign empty = (head == tail);
    assign full  = no_room || (head_nx == tail);

    // Pointer update: reset, re-seat on load, otherwise advance on accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head <= PG_W'(RST_BASE);
            tail <= PG_W'(RST_BASE);
        end else if (load) begin
            head <= load_base;
            tail <= load_base;
        end else begin
            if (alloc && !full)       head <= head_nx;
            if (release_pg && !empty) tail <= tail_nx;
        end
    end
endmodule

// File: rtl/pbm_ram.sv
// pbm_ram: word-wide store with a full-word port and a byte-lane port.
// Assumes one-cycle registered reads that return the old contents on a
// same-cycle write; the word port wins a same-word write collision.
module pbm_ram #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 2048,
    parameter int LANE_W  = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              a_en,
    input  logic              a_we,
    input  logic [AW-1:0]     a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    input  logic              b_en,
    input  logic              b_we,
    input  logic [AW-1:0]     b_addr,
    input  logic [LANE_W-1:0] b_lane,
    input  logic [7:0]        b_wdata,
    output logic [7:0]        b_rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Writes (byte port first so the word port overrides it) and registered reads.
    always_ff @(posedge clk) begin
        if (b_en && b_we) mem[b_addr][8*b_lane +: 8] <= b_wdata;
        if (a_en && a_we) mem[a_addr] <= a_wdata;
        if (a_en) a_rdata <= mem[a_addr];
        if (b_en) b_rdata <= mem[b_addr][8*b_lane +: 8];
    end
endmodule

// File: rtl/pbm_mgr.sv
// pbm_mgr: page-partitioned packet buffer manager. The receive ring covers pages
// 0..n-1 and the transmit ring covers n..PAGES-1, where n is the split register.
// A split write re-seats both rings and pulses a receive flush for one cycle.
// Assumes power-of-two geometry and that clients address pages themselves.
module pbm_mgr
    import pbm_pkg::*;
#(
    parameter int PAGES      = PBM_PAGES,
    parameter int PAGE_BYTES = PBM_PAGE_BYTES,
    parameter int WORD_BYTES = PBM_WORD_BYTES,
    parameter int RST_SPLIT  = PBM_RST_SPLIT,
    localparam int PG_W      = $clog2(PAGES),
    localparam int OFF_W     = $clog2(PAGE_BYTES),
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WIDX_W    = OFF_W - LANE_W,
    localparam int DATA_W    = 8 * WORD_BYTES,
    localparam int DEPTH     = PAGES * PAGE_BYTES / WORD_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              split_we,
    input  logic [PG_W-1:0]   split_val,
    output logic [PG_W-1:0]   split_o,
    output logic              rx_flush_o,
    input  logic              rx_alloc,
    input  logic              rx_release,
    input  logic              tx_alloc,
    input  logic              tx_release,
    output logic [PG_W-1:0]   rx_head,
    output logic [PG_W-1:0]   rx_tail,
    output logic              rx_full,
    output logic              rx_empty,
    output logic [PG_W-1:0]   tx_head,
    output logic [PG_W-1:0]   tx_tail,
    output logic              tx_full,
    output logic              tx_empty,
    input  logic              eng_en,
    input  logic              eng_we,
    input  logic [PG_W-1:0]   eng_page,
    input  logic [WIDX_W-1:0] eng_word,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] eng_rdata,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [PG_W-1:0]   host_page,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata
);
    logic [PG_W-1:0] split_q;

    logic [PG_W-1:0] base_w  [2];
    logic [PG_W-1:0] last_w  [2];
    logic [PG_W-1:0] loadb_w [2];
    logic [PG_W-1:0] head_w  [2];
    logic [PG_W-1:0] tail_w  [2];
    logic [1:0]      none_w, alloc_w, rel_w, full_w, empty_w;

    // Partition register and flush pulse.
    pbm_split #(.PG_W(PG_W), .RST_SPLIT(RST_SPLIT)) u_split (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (split_we),
        .wr_val  (split_val),
        .split_q (split_q),
        .flush_q (rx_flush_o)
    );
    assign split_o = split_q;

    // Region bounds derived from the current split; reload bases from the new one.
    assign base_w[REG_RX]  = '0;
    assign last_w[REG_RX]  = split_q - PG_W'(1);
    assign none_w[REG_RX]  = (split_q == '0);
    assign loadb_w[REG_RX] = '0;
    assign base_w[REG_TX]  = split_q;
    assign last_w[REG_TX]  = PG_W'(PAGES - 1);
    assign none_w[REG_TX]  = 1'b0;
    assign loadb_w[REG_TX] = split_val;

    assign alloc_w = {tx_alloc, rx_alloc};
    assign rel_w   = {tx_release, rx_release};

    // One pointer ring per region.
    for (genvar r = 0; r < 2; r++) begin : g_ring
        pbm_ring #(
            .PG_W     (PG_W),
            .RST_BASE ((r == REG_RX) ? 0 : RST_SPLIT)
        ) u_ring (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (split_we),
            .load_base  (loadb_w[r]),
            .base       (base_w[r]),
            .last       (last_w[r]),
            .no_room    (none_w[r]),
            .alloc      (alloc_w[r]),
            .release_pg (rel_w[r]),
            .head       (head_w[r]),
            .tail       (tail_w[r]),
            .full       (full_w[r]),
            .empty      (empty_w[r])
        );
    end

    assign rx_head  = head_w[REG_RX];
    assign rx_tail  = tail_w[REG_RX];
    assign rx_full  = full_w[REG_RX];
    assign rx_empty = empty_w[REG_RX];
    assign tx_head  = head_w[REG_TX];
    assign tx_tail  = tail_w[REG_TX];
    assign tx_full  = full_w[REG_TX];
    assign tx_empty = empty_w[REG_TX];

    // Packet store: page and offset concatenate into the word address.
    pbm_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LANE_W(LANE_W)) u_ram (
        .clk     (clk),
        .a_en    (eng_en),
        .a_we    (eng_we),
        .a_addr  ({eng_page, eng_word}),
        .a_wdata (eng_wdata),
        .a_rdata (eng_rdata),
        .b_en    (host_en),
        .b_we    (host_we),
        .b_addr  ({host_page, host_off[OFF_W-1:LANE_W]}),
        .b_lane  (host_off[LANE_W-1:0]),
        .b_wdata (host_wdata),
        .b_rdata (host_rdata)
    );
endmodule

// File: rtl/pbm_mgr_chk.sv
// pbm_mgr_chk: temporal checks on the page buffer manager ports, bound to pbm_mgr.
module pbm_mgr_chk #(
    parameter int PG_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            split_we,
    input logic [PG_W-1:0] split_val,
    input logic [PG_W-1:0] split_o,
    input logic            rx_flush_o,
    input logic            rx_alloc,
    input logic            tx_alloc,
    input logic [PG_W-1:0] rx_head,
    input logic [PG_W-1:0] rx_tail,
    input logic            rx_full,
    input logic            rx_empty,
    input logic [PG_W-1:0] tx_head,
    input logic            tx_full
);
    // R6: a split write re-seats the receive ring and pulses the flush.
    assert_split_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        split_we |=> (rx_flush_o && rx_head == '0 && rx_tail == '0 && split_o == $past(split_val)));

    // R6: the flush pulse appears only after a split write.
    assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush_o |-> $past(split_we));

    // R4: an allocate on a full ring leaves the head where it was.
    assert_full_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_alloc && rx_full && !split_we) |=> $stable(rx_head));

    // R2: an accepted transmit allocate moves the head.
    assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_alloc && !tx_full && !split_we) |=> (tx_head != $past(tx_head)));

    // R5: an empty receive region reports both full and empty.
    assert_zero_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (split_o == '0) |-> (rx_full && rx_empty));

    // R3: pointers stay inside their own region.
    assert_in_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (split_o != '0) |-> (rx_head < split_o && rx_tail < split_o && tx_head >= split_o));
endmodule

bind pbm_mgr pbm_mgr_chk #(.PG_W(PG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .split_we   (split_we),
    .split_val  (split_val),
    .split_o    (split_o),
    .rx_flush_o (rx_flush_o),
    .rx_alloc   (rx_alloc),
    .tx_alloc   (tx_alloc),
    .rx_head    (rx_head),
    .rx_tail    (rx_tail),
    .rx_full    (rx_full),
    .rx_empty   (rx_empty),
    .tx_head    (tx_head),
    .tx_full    (tx_full)
);

// File: tb/pbm_mgr_tb.sv
`timescale 1ns/1ps
module pbm_mgr_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        split_we = 1'b0;
    logic [4:0]  split_val = '0;
    logic [4:0]  split_o;
    logic        rx_flush_o;
    logic        rx_alloc = 1'b0, rx_release = 1'b0, tx_alloc = 1'b0, tx_release = 1'b0;
    logic [4:0]  rx_head, rx_tail, tx_head, tx_tail;
    logic        rx_full, rx_empty, tx_full, tx_empty;
    logic        eng_en = 1'b0, eng_we = 1'b0;
    logic [4:0]  eng_page = '0;
    logic [5:0]  eng_word = '0;
    logic [31:0] eng_wdata = '0;
    logic [31:0] eng_rdata;
    logic        host_en = 1'b0, host_we = 1'b0;
    logic [4:0]  host_page = '0;
    logic [7:0]  host_off = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;

    always #2 clk = ~clk;

    pbm_mgr u_dut (.*);

    typedef struct {
        int          due;
        int          sel;
        logic [31:0] exp;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;

    // Reference model state built from the requirements.
    int ms = 8, mrh = 0, mrt = 0, mth = 8, mtt = 8;
    logic [7:0] mb [int];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] actual(int sel);
        case (sel)
            0: return 32'(rx_head);
            1: return 32'(rx_tail);
            2: return 32'(tx_head);
            3: return 32'(tx_tail);
            4: return 32'(rx_full);
            5: return 32'(rx_empty);
            6: return 32'(tx_full);
            7: return 32'(tx_empty);
            8: return 32'(split_o);
            9: return 32'(rx_flush_o);
            10: return eng_rdata;
            default: return 32'(host_rdata);
        endcase
    endfunction

    task automatic chk(string req, int sel, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s sel=%0d actual=%h expected=%h", req, sel, act, exp);
        end
    endtask

    // Monitor: compare every expectation at the falling edge of its due cycle.
    always @(negedge clk) begin
        exp_t it;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it = sbq.pop_front();
            chk(it.req, it.sel, actual(it.sel), it.exp);
        end
    end

    function automatic void push(int sel, logic [31:0] exp, string req);
        exp_t it;
        it.due = cyc + 1;
        it.sel = sel;
        it.exp = exp;
        it.req = req;
        sbq.push_back(it);
    endfunction

    function automatic int nrx(int p);
        return (p == ms - 1) ? 0 : p + 1;
    endfunction

    function automatic int ntx(int p);
        return (p == 31) ? ms : p + 1;
    endfunction

    function automatic bit rxf();
        return (ms == 0) || (nrx(mrh) == mrt);
    endfunction

    function automatic bit txf();
        return ntx(mth) == mtt;
    endfunction

    function automatic void expect_all(string ptag, bit fl);
        string ftag;
        ftag = (ms == 0) ? "R5" : "R4";
        push(0, 32'(mrh), ptag);
        push(1, 32'(mrt), ptag);
        push(2, 32'(mth), ptag);
        push(3, 32'(mtt), ptag);
        push(4, 32'(rxf()), ftag);
        push(5, 32'(mrh == mrt), ftag);
        push(6, 32'(txf()), "R4");
        push(7, 32'(mth == mtt), "R4");
        push(8, 32'(ms), "R6");
        push(9, 32'(fl), "R6");
    endfunction

    task automatic drive_idle();
        split_we = 1'b0; rx_alloc = 1'b0; rx_release = 1'b0; tx_alloc = 1'b0; tx_release = 1'b0;
        eng_en = 1'b0; eng_we = 1'b0; host_en = 1'b0; host_we = 1'b0;
    endtask

    // Ring request driver: one clock of requests, then expected state pushed.
    task automatic step(bit ra, bit rr, bit ta, bit tr, string tag);
        bit rfull, rempty, tfull, tempty;
        @(negedge clk);
        drive_idle();
        rx_alloc = ra; rx_release = rr; tx_alloc = ta; tx_release = tr;
        rfull = rxf(); rempty = (mrh == mrt); tfull = txf(); tempty = (mth == mtt);
        if (ra && !rfull)  mrh = nrx(mrh);
        if (rr && !rempty) mrt = nrx(mrt);
        if (ta && !tfull)  mth = ntx(mth);
        if (tr && !tempty) mtt = ntx(mtt);
        expect_all(tag, 1'b0);
    endtask

    // R6: split write with ring requests in the same cycle (those must be ignored).
    task automatic set_split(int v, bit ra, bit ta);
        @(negedge clk);
        drive_idle();
        split_we = 1'b1; split_val = 5'(v); rx_alloc = ra; tx_alloc = ta; rx_release = 1'b1;
        ms = v; mrh = 0; mrt = 0; mth = v; mtt = v;
        expect_all("R6", 1'b1);
    endtask

    task automatic eng_write(int pg, int wd, logic [31:0] d);
        @(negedge clk);
        drive_idle();
        eng_en = 1'b1; eng_we = 1'b1; eng_page = 5'(pg); eng_word = 6'(wd); eng_wdata = d;
        for (int k = 0; k < 4; k++) mb[pg*256 + wd*4 + k] = d[8*k +: 8];
    endtask

    task automatic eng_read(int pg, int wd, string tag);
        logic [31:0] e;
        @(negedge clk);
        drive_idle();
        eng_en = 1'b1; eng_page = 5'(pg); eng_word = 6'(wd);
        for (int k = 0; k < 4; k++) e[8*k +: 8] = mb[pg*256 + wd*4 + k];
        push(10, e, tag);
    endtask

    task automatic host_write(int pg, int off, logic [7:0] d);
        @(negedge clk);
        drive_idle();
        host_en = 1'b1; host_we = 1'b1; host_page = 5'(pg); host_off = 8'(off); host_wdata = d;
        mb[pg*256 + off] = d;
    endtask

    task automatic host_read(int pg, int off);
        @(negedge clk);
        drive_idle();
        host_en = 1'b1; host_page = 5'(pg); host_off = 8'(off);
        push(11, 32'(mb[pg*256 + off]), "R8");
    endtask

    // R9: engine and host write the same word in one cycle; engine word is kept.
    task automatic dual_write(int pg, int wd, logic [31:0] d, int lane, logic [7:0] b);
        @(negedge clk);
        drive_idle();
        eng_en = 1'b1; eng_we = 1'b1; eng_page = 5'(pg); eng_word = 6'(wd); eng_wdata = d;
        host_en = 1'b1; host_we = 1'b1; host_page = 5'(pg); host_off = 8'(wd*4 + lane); host_wdata = b;
        for (int k = 0; k < 4; k++) mb[pg*256 + wd*4 + k] = d[8*k +: 8];
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_all("R1", 1'b0);

        // R2: plain allocate and release on both rings.
        step(1, 0, 1, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(1, 0, 0, 0, "R2");
        step(0, 1, 0, 1, "R2");
        // R3 R4: fill the receive ring until it wraps and refuses.
        for (int i = 0; i < 10; i++) step(1, 0, 0, 0, "R3 R4");
        // R3: drain with wrapping tail, then release on empty (ignored).
        for (int i = 0; i < 9; i++) step(0, 1, 0, 0, "R3 R2");
        // R3 R4: walk the transmit ring around its region.
        for (int i = 0; i < 30; i++) step(0, 0, 1, 1, "R3");
        for (int i = 0; i < 26; i++) step(0, 0, 1, 0, "R4");

        // R6 R5: empty receive region; transmit spans all pages.
        set_split(0, 1, 1);
        step(1, 0, 1, 0, "R5");
        step(1, 1, 0, 0, "R5");
        for (int i = 0; i < 33; i++) step(0, 0, 1, 0, "R5 R3");
        // R4: one-page receive region is always full.
        set_split(1, 0, 0);
        step(1, 0, 1, 0, "R4");
        step(1, 0, 0, 0, "R4");
        // R4: one-page transmit region.
        set_split(31, 1, 0);
        step(0, 0, 1, 0, "R4");
        for (int i = 0; i < 31; i++) step(1, 0, 0, 0, "R3 R4");
        set_split(8, 0, 0);
        step(1, 0, 1, 0, "R2");

        // R7: engine word accesses on several pages.
        eng_write(0, 0, 32'h0403_0201);
        eng_write(5, 63, 32'hdead_beef);
        eng_write(31, 17, 32'h1234_5678);
        eng_read(0, 0, "R7");
        eng_read(5, 63, "R7");
        eng_read(31, 17, "R7");
        // R8: host byte lanes of an engine-written word.
        for (int k = 0; k < 4; k++) host_read(5, 252 + k);
        // R8: host write changes only its lane.
        host_write(31, 17*4 + 2, 8'ha5);
        eng_read(31, 17, "R8");
        host_write(2, 9, 8'h3c);
        host_read(2, 9);
        // R9: same-word collision.
        dual_write(12, 3, 32'hcafe_f00d, 1, 8'h77);
        eng_read(12, 3, "R9");
        host_read(12, 13);

        @(negedge clk);
        drive_idle();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule